// File: doc/BRIEF.md
# Seed-Driven Scan Vector Expander

This block rebuilds full scan-chain test vectors from short seeds sent by an external tester. The tester offers one seed per vector over a valid/ready handshake. The block copies the accepted seed into a linear feedback shift register as a whole. It then clocks that register by itself, with no further tester input, for exactly as many cycles as the scan chain is long. Each cycle it drives one generated bit onto the serial scan-data output and holds scan-enable high.

When the last bit has been shifted, scan-enable drops for a single capture cycle, which is flagged on its own output. The block then raises its ready output again and waits for the next seed. A new vector can only come from a new seed. The register width is a parameter, sized from the largest number of care bits that any one vector needs. The feedback taps and the chain length are also parameters.

Top module: `seed_scan_expander`

## Requirements
- R1: After reset, `seed_ready` is 1 and `scan_en`, `scan_data` and `capture` are 0.
- R2: A seed is accepted on a clock edge where `seed_valid` and `seed_ready` are both 1. In the next cycle `seed_ready` is 0 and `scan_en` is 1.
- R3: After each acceptance, `scan_en` stays high for exactly CHAIN_LEN consecutive cycles, starting in the cycle after the accepting edge.
- R4: In the k-th cycle with `scan_en` high (k counted from 0), `scan_data` equals bit LFSR_W-1 of the register after k steps from the seed. One step maps state s to {s[LFSR_W-2:0], XOR-reduce(s & TAP_MASK)}.
- R5: Whenever `scan_en` is 0, `scan_data` is 0.
- R6: The cycle after the last shift has `scan_en` 0 and `capture` 1, for exactly one cycle. In the cycle after that, `seed_ready` is 1.
- R7: While `seed_ready` is 0, `seed_valid` and `seed_data` are ignored. A seed presented during an expansion changes neither the vector being shifted nor the sequence timing.
- R8: An all-zero seed is accepted normally and yields CHAIN_LEN zero bits with the usual timing.
- R9: At most one of `seed_ready`, `scan_en` and `capture` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_valid | input | 1 | Tester offers a seed |
| seed_data | input | LFSR_W | Seed value |
| seed_ready | output | 1 | Block will take a seed on this edge |
| scan_data | output | 1 | Serial bit to the scan-chain input |
| scan_en | output | 1 | Scan shift enable |
| capture | output | 1 | One-cycle capture slot after the shift |

## Verification
The assertions assume that reset is held for at least one clock before any handshake. They also assume `seed_valid` never carries X or Z while reset is low. The bench meets both: it holds reset for several cycles, drives `seed_valid` low from time zero, and changes it only on falling edges. It sweeps every seed of an 8-bit register into a 10-bit chain and compares each vector against a model of the step rule in R4. It also presents a competing seed in the middle of an expansion to show that the block ignores it.

// File: rtl/sse_pkg.sv
package sse_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_SHIFT   = 2'd1,
    SEQ_CAPTURE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sse_lfsr.sv
module sse_lfsr #(
  parameter int unsigned LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK = 16'hB400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [LFSR_W-1:0] seed,
  output logic [LFSR_W-1:0] next_o
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  // Fibonacci feedback: parity of the tapped stages enters at bit 0
  assign fb     = ^(state_q & TAP_MASK);
  assign next_o = {state_q[LFSR_W-2:0], fb};

  always_ff @(posedge clk) begin
    if (rst)       state_q <= '0;
    else if (load) state_q <= seed;
    else if (step) state_q <= next_o;
  end
endmodule

// File: rtl/sse_shift_counter.sv
module sse_shift_counter #(
  parameter int unsigned CHAIN_LEN = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic at_last
);
  localparam int unsigned CNT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHAIN_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign at_last = (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (inc)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sse_sequencer.sv
module sse_sequencer
  import sse_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic seed_valid,
  input  logic at_last,
  output logic load,
  output logic step,
  output logic last_step,
  output logic ready_q,
  output logic en_q,
  output logic cap_q
);
  seq_state_t state_q, state_d;

  assign load      = (state_q == SEQ_IDLE) && seed_valid;
  assign step      = (state_q == SEQ_SHIFT);
  assign last_step = step && at_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:    if (seed_valid) state_d = SEQ_SHIFT;
      SEQ_SHIFT:   if (at_last)    state_d = SEQ_CAPTURE;
      SEQ_CAPTURE: state_d = SEQ_IDLE;
      default:     state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      ready_q <= 1'b1;
      en_q    <= 1'b0;
      cap_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= (state_d == SEQ_IDLE);
      en_q    <= (state_d == SEQ_SHIFT);
      cap_q   <= (state_d == SEQ_CAPTURE);
    end
  end
endmodule

// File: rtl/seed_scan_expander.sv
module seed_scan_expander #(
  parameter int unsigned LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK = 16'hB400,
  parameter int unsigned CHAIN_LEN = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed_valid,
  input  logic [LFSR_W-1:0] seed_data,
  output logic              seed_ready,
  output logic              scan_data,
  output logic              scan_en,
  output logic              capture
);
  localparam int unsigned MSB = LFSR_W - 1;

  logic              load, step, last_step, at_last;
  logic [LFSR_W-1:0] lfsr_next;
  logic              dout_q;

  sse_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .seed_valid (seed_valid),
    .at_last    (at_last),
    .load       (load),
    .step       (step),
    .last_step  (last_step),
    .ready_q    (seed_ready),
    .en_q       (scan_en),
    .cap_q      (capture)
  );

  sse_shift_counter #(.CHAIN_LEN(CHAIN_LEN)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear   (load),
    .inc     (step),
    .at_last (at_last)
  );

  sse_lfsr #(.LFSR_W(LFSR_W), .TAP_MASK(TAP_MASK)) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .step   (step),
    .seed   (seed_data),
    .next_o (lfsr_next)
  );

  // Output bit register: seed MSB first, then the MSB of each successive state
  always_ff @(posedge clk) begin
    if (rst)                     dout_q <= 1'b0;
    else if (load)               dout_q <= seed_data[MSB];
    else if (step && !last_step) dout_q <= lfsr_next[MSB];
    else                         dout_q <= 1'b0;
  end

  assign scan_data = dout_q;
endmodule

// File: rtl/seed_scan_expander_checker.sv
module seed_scan_expander_checker #(
  parameter int unsigned CHAIN_LEN = 24
) (
  input logic clk,
  input logic rst,
  input logic seed_valid,
  input logic seed_ready,
  input logic scan_data,
  input logic scan_en,
  input logic capture
);
  localparam int unsigned RUN_W = $clog2(CHAIN_LEN + 1) + 1;
  logic [RUN_W-1:0] run_q;

  // Counts consecutive cycles with scan_en high
  always_ff @(posedge clk) begin
    if (rst)          run_q <= '0;
    else if (scan_en) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (seed_valid && seed_ready) |=> (scan_en && !seed_ready));

  assert_en_bound_R3: assert property (@(posedge clk) disable iff (rst)
    scan_en |-> (run_q < RUN_W'(CHAIN_LEN)));

  assert_en_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(scan_en) |-> (run_q == RUN_W'(CHAIN_LEN)));

  assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !scan_en |-> !scan_data);

  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(scan_en) |-> capture);

  assert_ready_after_cap_R6: assert property (@(posedge clk) disable iff (rst)
    capture |=> (seed_ready && !capture));

  assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({seed_ready, scan_en, capture}));
endmodule

bind seed_scan_expander seed_scan_expander_checker #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .seed_valid (seed_valid),
  .seed_ready (seed_ready),
  .scan_data  (scan_data),
  .scan_en    (scan_en),
  .capture    (capture)
);

// File: tb/seed_scan_expander_bench.sv
module seed_scan_expander_bench;
  localparam int unsigned W   = 8;
  localparam logic [W-1:0] TAPS = 8'hB8;
  localparam int unsigned L   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seed_valid = 1'b0;
  logic [W-1:0] seed_data = '0;
  logic seed_ready, scan_data, scan_en, capture;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  seed_scan_expander #(.LFSR_W(W), .TAP_MASK(TAPS), .CHAIN_LEN(L)) u_seed_scan_expander (
    .clk(clk), .rst(rst), .seed_valid(seed_valid), .seed_data(seed_data),
    .seed_ready(seed_ready), .scan_data(scan_data), .scan_en(scan_en), .capture(capture)
  );

  // Expected vector from the R4 step rule; bit k is the k-th shifted bit
  function automatic logic [L-1:0] expand(input logic [W-1:0] seed);
    logic [W-1:0] s = seed;
    logic [L-1:0] v = '0;
    for (int k = 0; k < L; k++) begin
      v[k] = s[W-1];
      s = {s[W-2:0], ^(s & TAPS)};
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one seed; if intrude is set, a different seed is offered mid-expansion (R7)
  task automatic run_seed(input logic [W-1:0] seed, input bit intrude, input string req);
    logic [L-1:0] vec = '0;
    int en_cnt = 0;
    int quiet_bad = 0;
    @(negedge clk);
    seed_valid = 1'b1;
    seed_data  = seed;
    @(negedge clk);
    seed_valid = 1'b0;
    check("R2 ready low/en high after accept", {seed_ready, scan_en}, 2'b01);
    for (int k = 0; k < L; k++) begin
      if (k > 0) @(negedge clk);
      if (intrude && k == 2) begin
        seed_valid = 1'b1;
        seed_data  = ~seed;
      end
      vec[k] = scan_data;
      if (scan_en) en_cnt++;
    end
    @(negedge clk);
    seed_valid = 1'b0;
    check("R3 scan_en cycles", en_cnt, L);
    check("R6 capture cycle en/cap/ready", {scan_en, capture, seed_ready}, 3'b010);
    if (scan_data) quiet_bad++;
    check({req, " vector"}, vec, expand(seed));
    @(negedge clk);
    check("R6 ready after capture", {seed_ready, capture, scan_en}, 3'b100);
    if (scan_data) quiet_bad++;
    check("R5 data zero when idle", quiet_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset outputs", {seed_ready, scan_en, scan_data, capture}, 4'b1000);

    // R8: all-zero seed gives a constant-zero vector
    run_seed('0, 1'b0, "R8 zero seed");
    check("R8 zero vector model", expand('0), '0);

    // R4: sweep every seed
    for (int s = 0; s < (1 << W); s++) run_seed(W'(s), 1'b0, "R4 sweep");

    // R7: competing seed during expansion must be ignored
    run_seed(8'h5A, 1'b1, "R7 intrude");
    run_seed(8'h01, 1'b1, "R7 intrude");

    // Idle period: ready holds, nothing shifts (R5, R9)
    repeat (3) begin
      @(negedge clk);
      check("R9 idle outputs", {seed_ready, scan_en, capture, scan_data}, 4'b1000);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule